// File: doc/BRIEF.md
# Lowest-Occupancy Dual Fetch Selector

This block decides, every cycle, which two of eight hardware threads in a simultaneous multithreaded front end are allowed to fetch. For each thread it keeps a running count of that thread's instructions that have been fetched but not yet sent to execution, covering decode, rename and the instruction queue. The two eligible threads holding the fewest such instructions receive the grants. Threads that drain their instructions quickly therefore get more fetch slots, and a thread that is clogging the queue is held back.

The fetch unit reports how many instructions it brought in for each thread. The issue logic reports how many left for execution, and the flush logic reports how many were squashed. The counts update on the clock edge. The grants are a combinational function of the registered counts and of the current eligibility mask. The first grant always names the thread with the lower count of the two that are chosen.

Top module: `lowcnt_fetch_pick`

## Requirements
- R1: When at least two threads are eligible, both grant valid bits are 1.
- R2: On each clock edge, every thread's count becomes its old count plus the fetched amount, minus the issued amount, minus the flushed amount. The change shows in the grants from the following cycle onward.
- R3: A thread whose eligible bit is 0 is never granted. With one eligible thread, only grant 0 is valid and it names that thread. With none, both valid bits are 0. Grant 1 is valid only when grant 0 is valid.
- R4: When both grants are valid, their thread IDs differ.
- R5: Grant 0 names the eligible thread with the smallest count. Grant 1 names the smallest among the remaining eligible threads. On equal counts the lower thread ID wins, and it goes to grant 0.
- R6: A count that would go above 63 (2^6-1) stays at 63. A count that would go below 0 stays at 0. Neither wraps.
- R7: Reset (active-low `rstN`) clears every count to 0. Right after reset, with all threads eligible, the grants are thread 0 then thread 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| fetchAmt | input | 8x3 | Per-thread count of instructions fetched this cycle |
| issueAmt | input | 8x3 | Per-thread count of instructions issued to execution this cycle |
| flushAmt | input | 8x3 | Per-thread count of instructions squashed this cycle |
| eligible | input | 8 | Per-thread fetch-eligible mask |
| grant0Valid | output | 1 | First grant is valid |
| grant0Id | output | 3 | First grant thread ID (lower count) |
| grant1Valid | output | 1 | Second grant is valid |
| grant1Id | output | 3 | Second grant thread ID |

## Verification
The two functions that can land in the same cycle are an increment from fetch and a decrement from issue and flush on the same thread. Sometimes the decrement is large enough to hit the floor, or the increment is large enough to hit the ceiling. The bench drives all three amounts onto one thread in one cycle. It does this both in directed cases that sit at 0 and at 63, and in a long pseudo-random run. Each result is judged by the ranking it produces in the next cycle. Its reference model applies the net change with clamping and ranks the eligible threads by count and ID.

// File: rtl/lfp_pkg.sv
package lfp_pkg;
  // Update strobes sent from the update control to the counter bank.
  typedef struct packed {
    logic apply;    // some amount is nonzero for this thread
    logic clampHi;  // net result exceeds the ceiling
    logic clampLo;  // net result falls below zero
  } cntStrobe_t;
endpackage

// File: rtl/lfp_update_ctrl.sv
module lfp_update_ctrl
  import lfp_pkg::*;
#(
  parameter int NUM_THREADS = 8,
  parameter int CNT_W = 6,
  parameter int AMT_W = 3
) (
  input  logic [NUM_THREADS-1:0][CNT_W-1:0] counts,
  input  logic [NUM_THREADS-1:0][AMT_W-1:0] fetchAmt,
  input  logic [NUM_THREADS-1:0][AMT_W-1:0] issueAmt,
  input  logic [NUM_THREADS-1:0][AMT_W-1:0] flushAmt,
  output cntStrobe_t [NUM_THREADS-1:0]      strobes
);
  localparam int SUM_W = CNT_W + AMT_W + 2;
  localparam logic [SUM_W-1:0] CEIL = SUM_W'((1 << CNT_W) - 1);

  for (genvar t = 0; t < NUM_THREADS; t++) begin : g_thr
    logic [SUM_W-1:0] upSum;
    logic [SUM_W-1:0] downSum;
    always_comb begin
      upSum   = SUM_W'(counts[t]) + SUM_W'(fetchAmt[t]);
      downSum = SUM_W'(issueAmt[t]) + SUM_W'(flushAmt[t]);
      strobes[t].apply   = (fetchAmt[t] != '0) || (issueAmt[t] != '0) || (flushAmt[t] != '0);
      strobes[t].clampLo = downSum > upSum;
      strobes[t].clampHi = (downSum <= upSum) && ((upSum - downSum) > CEIL);
    end
  end
endmodule

// File: rtl/lfp_count_bank.sv
module lfp_count_bank
  import lfp_pkg::*;
#(
  parameter int NUM_THREADS = 8,
  parameter int CNT_W = 6,
  parameter int AMT_W = 3
) (
  input  logic                              clk,
  input  logic                              rstN,
  input  logic [NUM_THREADS-1:0][AMT_W-1:0] fetchAmt,
  input  logic [NUM_THREADS-1:0][AMT_W-1:0] issueAmt,
  input  logic [NUM_THREADS-1:0][AMT_W-1:0] flushAmt,
  input  cntStrobe_t [NUM_THREADS-1:0]      strobes,
  output logic [NUM_THREADS-1:0][CNT_W-1:0] counts
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  for (genvar t = 0; t < NUM_THREADS; t++) begin : g_cnt
    always_ff @(posedge clk) begin
      if (!rstN) begin
        counts[t] <= '0;
      end else if (strobes[t].clampLo) begin
        counts[t] <= '0;
      end else if (strobes[t].clampHi) begin
        counts[t] <= CNT_MAX;
      end else if (strobes[t].apply) begin
        counts[t] <= counts[t] + CNT_W'(fetchAmt[t]) - CNT_W'(issueAmt[t]) - CNT_W'(flushAmt[t]);
      end
    end

    AST_CEIL_HOLD: assert property (@(posedge clk) disable iff (!rstN)
      (counts[t] == CNT_MAX && issueAmt[t] == '0 && flushAmt[t] == '0) |=> counts[t] == CNT_MAX); // R6
    AST_FLOOR_HOLD: assert property (@(posedge clk) disable iff (!rstN)
      (counts[t] == '0 && fetchAmt[t] == '0) |=> counts[t] == '0); // R6
    AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (!rstN)
      (fetchAmt[t] == '0 && issueAmt[t] == '0 && flushAmt[t] == '0) |=> $stable(counts[t])); // R2
  end

  AST_RESET_CLEAR: assert property (@(posedge clk)
    !rstN |=> counts == '0); // R7
endmodule

// File: rtl/lfp_select.sv
module lfp_select #(
  parameter int NUM_THREADS = 8,
  parameter int CNT_W = 6,
  parameter int TID_W = $clog2(NUM_THREADS)
) (
  input  logic                              clk,
  input  logic                              rstN,
  input  logic [NUM_THREADS-1:0][CNT_W-1:0] counts,
  input  logic [NUM_THREADS-1:0]            eligible,
  output logic                              grant0Valid,
  output logic [TID_W-1:0]                  grant0Id,
  output logic                              grant1Valid,
  output logic [TID_W-1:0]                  grant1Id
);
  // First pass: lowest count, scanning upward so ties keep the lower ID.
  always_comb begin
    grant0Valid = 1'b0;
    grant0Id    = '0;
    for (int t = 0; t < NUM_THREADS; t++) begin
      if (eligible[t] && (!grant0Valid || counts[t] < counts[grant0Id])) begin
        grant0Valid = 1'b1;
        grant0Id    = TID_W'(t);
      end
    end
  end

  // Second pass: same scan with the first winner masked out.
  always_comb begin
    grant1Valid = 1'b0;
    grant1Id    = '0;
    for (int t = 0; t < NUM_THREADS; t++) begin
      if (eligible[t] && !(grant0Valid && grant0Id == TID_W'(t)) &&
          (!grant1Valid || counts[t] < counts[grant1Id])) begin
        grant1Valid = 1'b1;
        grant1Id    = TID_W'(t);
      end
    end
  end

  AST_G0_ELIG: assert property (@(posedge clk) disable iff (!rstN)
    grant0Valid |-> eligible[grant0Id]); // R3
  AST_G1_ELIG: assert property (@(posedge clk) disable iff (!rstN)
    grant1Valid |-> eligible[grant1Id]); // R3
  AST_VALID_ORDER: assert property (@(posedge clk) disable iff (!rstN)
    grant1Valid |-> grant0Valid); // R3
  AST_TWO_GRANTS: assert property (@(posedge clk) disable iff (!rstN)
    ($countones(eligible) >= 2) |-> (grant0Valid && grant1Valid)); // R1
  AST_DISTINCT: assert property (@(posedge clk) disable iff (!rstN)
    (grant0Valid && grant1Valid) |-> grant0Id != grant1Id); // R4
  AST_RANK_ORDER: assert property (@(posedge clk) disable iff (!rstN)
    (grant0Valid && grant1Valid) |->
      (counts[grant0Id] < counts[grant1Id] ||
       (counts[grant0Id] == counts[grant1Id] && grant0Id < grant1Id))); // R5

  for (genvar t = 0; t < NUM_THREADS; t++) begin : g_chk
    AST_G0_MIN: assert property (@(posedge clk) disable iff (!rstN)
      (grant0Valid && eligible[t]) |-> counts[t] >= counts[grant0Id]); // R5
  end
endmodule

// File: rtl/lowcnt_fetch_pick.sv
module lowcnt_fetch_pick
  import lfp_pkg::*;
#(
  parameter int NUM_THREADS = 8,
  parameter int CNT_W = 6,
  parameter int AMT_W = 3,
  localparam int TID_W = $clog2(NUM_THREADS)
) (
  input  logic                              clk,
  input  logic                              rstN,
  input  logic [NUM_THREADS-1:0][AMT_W-1:0] fetchAmt,
  input  logic [NUM_THREADS-1:0][AMT_W-1:0] issueAmt,
  input  logic [NUM_THREADS-1:0][AMT_W-1:0] flushAmt,
  input  logic [NUM_THREADS-1:0]            eligible,
  output logic                              grant0Valid,
  output logic [TID_W-1:0]                  grant0Id,
  output logic                              grant1Valid,
  output logic [TID_W-1:0]                  grant1Id
);
  logic [NUM_THREADS-1:0][CNT_W-1:0] counts;
  cntStrobe_t [NUM_THREADS-1:0]      strobes;

  lfp_update_ctrl #(.NUM_THREADS(NUM_THREADS), .CNT_W(CNT_W), .AMT_W(AMT_W)) uCtrl (
    .counts(counts), .fetchAmt(fetchAmt), .issueAmt(issueAmt),
    .flushAmt(flushAmt), .strobes(strobes)
  );

  lfp_count_bank #(.NUM_THREADS(NUM_THREADS), .CNT_W(CNT_W), .AMT_W(AMT_W)) uBank (
    .clk(clk), .rstN(rstN), .fetchAmt(fetchAmt), .issueAmt(issueAmt),
    .flushAmt(flushAmt), .strobes(strobes), .counts(counts)
  );

  lfp_select #(.NUM_THREADS(NUM_THREADS), .CNT_W(CNT_W), .TID_W(TID_W)) uSel (
    .clk(clk), .rstN(rstN), .counts(counts), .eligible(eligible),
    .grant0Valid(grant0Valid), .grant0Id(grant0Id),
    .grant1Valid(grant1Valid), .grant1Id(grant1Id)
  );
endmodule

// File: tb/lowcnt_fetch_pick_test.sv
`timescale 1ns/1ps
module lowcnt_fetch_pick_test;
  localparam int NT = 8;
  localparam int AW = 3;
  localparam int CMAX = 63;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [NT-1:0][AW-1:0] fetchAmt = '0;
  logic [NT-1:0][AW-1:0] issueAmt = '0;
  logic [NT-1:0][AW-1:0] flushAmt = '0;
  logic [NT-1:0] eligible = '0;
  logic grant0Valid, grant1Valid;
  logic [2:0] grant0Id, grant1Id;

  lowcnt_fetch_pick uut (
    .clk(clk), .rstN(rstN), .fetchAmt(fetchAmt), .issueAmt(issueAmt),
    .flushAmt(flushAmt), .eligible(eligible),
    .grant0Valid(grant0Valid), .grant0Id(grant0Id),
    .grant1Valid(grant1Valid), .grant1Id(grant1Id)
  );

  always #4 clk = ~clk;

  int total = 0;
  int bad = 0;
  bit finished = 0;
  int model [NT];
  logic [7:0] expQ [$];
  string tagQ [$];
  event sampleEv;

  // Monitor: pops the expected grant word and compares with the outputs.
  always @(sampleEv) begin
    logic [7:0] exp, act;
    string tag;
    exp = expQ.pop_front();
    tag = tagQ.pop_front();
    act = {grant0Valid, grant0Id, grant1Valid, grant1Id};
    if (!exp[7]) act[6:4] = 3'd0;
    if (!exp[3]) act[2:0] = 3'd0;
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: grants v0=%0b id0=%0d v1=%0b id1=%0d, expected v0=%0b id0=%0d v1=%0b id1=%0d",
               tag, act[7], act[6:4], act[3], act[2:0], exp[7], exp[6:4], exp[3], exp[2:0]);
    end
  end

  function automatic logic [7:0] rank(input logic [NT-1:0] el);
    int b0 = -1, b1 = -1;
    for (int t = 0; t < NT; t++)
      if (el[t] && (b0 < 0 || model[t] < model[b0])) b0 = t;
    for (int t = 0; t < NT; t++)
      if (el[t] && t != b0 && (b1 < 0 || model[t] < model[b1])) b1 = t;
    return {b0 >= 0, (b0 >= 0) ? 3'(b0) : 3'd0, b1 >= 0, (b1 >= 0) ? 3'(b1) : 3'd0};
  endfunction

  // Driver: applies one cycle of stimulus and queues the expected grants.
  task automatic step(input logic [NT-1:0][AW-1:0] f, input logic [NT-1:0][AW-1:0] i,
                      input logic [NT-1:0][AW-1:0] fl, input logic [NT-1:0] el, input string tag);
    @(negedge clk);
    fetchAmt = f; issueAmt = i; flushAmt = fl; eligible = el;
    #1;
    expQ.push_back(rank(el));
    tagQ.push_back(tag);
    ->sampleEv;
    #1;
    for (int t = 0; t < NT; t++) begin
      int n = model[t] + int'(f[t]) - int'(i[t]) - int'(fl[t]);
      model[t] = (n < 0) ? 0 : (n > CMAX) ? CMAX : n;
    end
  endtask

  function automatic logic [NT-1:0][AW-1:0] one(input int t, input int v);
    logic [NT-1:0][AW-1:0] r = '0;
    r[t] = AW'(v);
    return r;
  endfunction

  initial begin
    logic [NT-1:0][AW-1:0] z = '0;
    logic [31:0] lfsr = 32'hACE1_2345;
    for (int t = 0; t < NT; t++) model[t] = 0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R7: counts clear, all eligible -> 0 then 1
    step(z, z, z, 8'hFF, "R7 reset");
    // R2: fetch into threads 0 and 1, ranking shifts to 2,3
    step(one(0, 5) | one(1, 3), z, z, 8'hFF, "R2 fetch");
    step(z, z, z, 8'hFF, "R2 after fetch");
    step(z, z, z, 8'h03, "R5 order by count");
    // R3: single and no eligible thread
    step(z, z, z, 8'h20, "R3 single");
    step(z, z, z, 8'h00, "R3 none");
    // R2 same-cycle fetch, issue and flush on thread 1 (3+4-2-3=2)
    step(one(1, 4), one(1, 2), one(1, 3), 8'h03, "R2 mixed");
    step(z, z, z, 8'h03, "R2 mixed result");
    // R6 ceiling: thread 2 to 63, thread 4 to 62
    for (int k = 0; k < 12; k++) step(one(2, 7), z, z, 8'h14, "R6 fill");
    for (int k = 0; k < 8; k++) step(one(4, 7), z, z, 8'h14, "R6 fill");
    step(one(4, 6), z, z, 8'h14, "R6 fill");
    step(z, z, z, 8'h14, "R6 ceiling");
    step(z, one(2, 1), z, 8'h14, "R6 ceiling");
    step(z, z, z, 8'h14, "R5 tie lower id");
    // R6 floor: thread 6 at 0 with big decrement, thread 7 at 2
    step(one(7, 2), one(6, 5), one(6, 4), 8'hC0, "R6 floor");
    step(one(6, 1), z, z, 8'hC0, "R6 floor");
    step(z, z, z, 8'hC0, "R6 floor result");
    // R1 R4 R5: pseudo-random traffic
    for (int k = 0; k < 400; k++) begin
      logic [NT-1:0][AW-1:0] f, i, fl;
      for (int t = 0; t < NT; t++) begin
        lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
        f[t] = lfsr[2:0];
        i[t] = lfsr[5:3] & {3{lfsr[9]}};
        fl[t] = lfsr[8:6] & {3{lfsr[10] & lfsr[11]}};
      end
      step(f, i, fl, (lfsr[15:12] == 0) ? lfsr[23:16] & 8'h11 : lfsr[23:16], "R1 R4 R5 random");
    end
    step(z, z, z, 8'hFF, "R5 final");
    @(negedge clk);
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      total++; bad++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule